// File: doc/BRIEF.md
# Masked Command Register Write Port

This block takes a stream of 32-bit command words, one per clock, and stores each word's payload in a file of 24-bit registers. The top byte of the word selects the register. The payload is not always written whole. A dedicated mask register chooses which payload bits replace the stored bits, and the remaining bits keep their old values. A mask loaded by software stays in force for exactly one following command. After that command the mask returns to all ones by itself, unless that command was another write to the mask register.

After each accepted command, the block decodes the address and raises one-cycle side-effect strobes for the engines downstream. These strobes are:
- a drawing-finished pulse or a warning,
- a token update with an optional interrupt request,
- a bounding-box reload carrying two 10-bit bounds,
- a performance-counter clear,
- a scissor-changed pulse,
- a copy trigger,
- a texture-load start.

A combinational read port returns the stored value of any address, including the current mask.

Top module: `mcw_top`

## Requirements
- R1: A command word carries the register address in bits 31:24 and the payload in bits 23:0. A command is accepted on a rising edge where cmd_valid and cmd_ready are both high. cmd_ready is high whenever rst is low. From the cycle after the accepting edge, the stored result is visible on rd_data when rd_addr selects that address.
- R2: The stored result equals (old AND NOT mask) OR (payload AND mask), using the mask that is current when the command is accepted.
- R3: After reset, every register reads 0, the mask address 0xFE reads 0xFFFFFF, and no strobe is high.
- R4: The mask lives at address 0xFE, and a write to it merges like any other write. After any accepted write to another address, the mask reads 0xFFFFFF again. After a write to 0xFE, the merged value is the mask used by the next command.
- R5: A write to address 0x45 raises draw_finish when bits 7:0 of the merged value equal 0x02. For any other value it raises draw_warn instead.
- R6: A write to 0x47 or 0x48 raises token_strobe, with token_value equal to bits 15:0 of the merged value. token_irq is raised together with token_strobe only for address 0x48.
- R7: A write to 0x55 raises bbox_load bit 0, and a write to 0x56 raises bbox_load bit 1. In both cases bbox_upper carries merged bits 19:10 and bbox_lower carries merged bits 9:0.
- R8: A write to any of 0x20, 0x21 or 0x59 raises one scissor_changed pulse.
- R9: Each of the following addresses raises its own one-cycle strobe:
  - 0x52 raises copy_start.
  - 0x57 raises perf_clear.
  - 0x65 raises texload_start.
- R10: Every strobe is high only in the single cycle after the accepting edge. A command raises at most one strobe class. Addresses not listed in R5 to R9 raise no strobe.
- R11: Commands may arrive on consecutive cycles. Each one is merged with the result of the one before it, including a mask written one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_word | input | 32 | Address in 31:24, payload in 23:0 |
| rd_addr | input | 8 | Read port address |
| rd_data | output | 24 | Stored value at rd_addr (mask at 0xFE) |
| draw_finish | output | 1 | Drawing-finished pulse |
| draw_warn | output | 1 | Draw-done written with an unknown code |
| token_strobe | output | 1 | New token value |
| token_irq | output | 1 | Token comes with an interrupt request |
| token_value | output | 16 | Token value |
| bbox_load | output | 2 | Bounding-box pair reload, one bit per pair |
| bbox_upper | output | 10 | Upper bound for the reload |
| bbox_lower | output | 10 | Lower bound for the reload |
| perf_clear | output | 1 | Performance-counter clear |
| scissor_changed | output | 1 | Scissor setup changed |
| copy_start | output | 1 | Copy trigger |
| texload_start | output | 1 | Texture-load start |

## Verification
The masked merge and the strobe decode act on the same command in the same cycle. A strobe's data must therefore come from the merged value, not from the raw payload. The bench provokes this by loading a partial mask and sending a token, draw-done or bounding-box command on the very next cycle. It then compares token_value, the finish/warn choice and the bounds against its own merge of the old contents. A second overlap is mask expiry under back-to-back traffic: a mask write directly followed by two data writes must affect only the first of them. The bench judges this through rd_data for both targets and through the mask address.

// File: rtl/mcw_pkg.sv
package mcw_pkg;

    localparam int MCW_ADDR_W = 8;
    localparam int MCW_DATA_W = 24;
    localparam int MCW_CMD_W  = MCW_ADDR_W + MCW_DATA_W;
    localparam int TOKEN_W    = 16;
    localparam int BBOX_W     = 10;
    localparam int NUM_BBOX   = 2;

    localparam logic [MCW_ADDR_W-1:0] A_MASK        = 8'hFE;
    localparam logic [MCW_ADDR_W-1:0] A_DRAWDONE    = 8'h45;
    localparam logic [MCW_ADDR_W-1:0] A_TOKEN       = 8'h47;
    localparam logic [MCW_ADDR_W-1:0] A_TOKEN_IRQ   = 8'h48;
    localparam logic [MCW_ADDR_W-1:0] A_SCISSOR_TL  = 8'h20;
    localparam logic [MCW_ADDR_W-1:0] A_SCISSOR_BR  = 8'h21;
    localparam logic [MCW_ADDR_W-1:0] A_SCISSOR_OFS = 8'h59;
    localparam logic [MCW_ADDR_W-1:0] A_COPY        = 8'h52;
    localparam logic [MCW_ADDR_W-1:0] A_BBOX_BASE   = 8'h55;
    localparam logic [MCW_ADDR_W-1:0] A_PERF_CLR    = 8'h57;
    localparam logic [MCW_ADDR_W-1:0] A_TEXLOAD     = 8'h65;

    localparam logic [7:0] FINISH_CODE = 8'h02;

    typedef struct packed {
        logic [MCW_ADDR_W-1:0] addr;
        logic [MCW_DATA_W-1:0] payload;
    } cmd_t;

    typedef struct packed {
        logic                finish;
        logic                warn;
        logic                token;
        logic                token_irq;
        logic [NUM_BBOX-1:0] bbox;
        logic                perf;
        logic                scissor;
        logic                copy;
        logic                texload;
    } strobe_t;

    function automatic logic is_scissor(input logic [MCW_ADDR_W-1:0] a);
        return (a == A_SCISSOR_TL) || (a == A_SCISSOR_BR) || (a == A_SCISSOR_OFS);
    endfunction

endpackage

// File: rtl/mcw_mask_ctl.sv
module mcw_mask_ctl
    import mcw_pkg::*;
#(
    parameter int ADDR_W = MCW_ADDR_W,
    parameter int DATA_W = MCW_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] payload,
    output logic [DATA_W-1:0] merged,
    output logic [DATA_W-1:0] mask_q
);
    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    always_comb begin
        merged = (old_val & ~mask_q) | (payload & mask_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= ALL_ONES;
        end else if (wr_en) begin
            if (wr_addr == A_MASK) begin
                mask_q <= merged;
            end else begin
                mask_q <= ALL_ONES;
            end
        end
    end
endmodule

// File: rtl/mcw_regfile.sv
module mcw_regfile #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] old_addr,
    output logic [DATA_W-1:0] old_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[i] <= '0;
            end else if (we && (waddr == ADDR_W'(i))) begin
                mem[i] <= wdata;
            end
        end
    end

    assign old_data = mem[old_addr];
    assign rd_data  = mem[rd_addr];
endmodule

// File: rtl/mcw_decode.sv
module mcw_decode
    import mcw_pkg::*;
#(
    parameter int ADDR_W   = MCW_ADDR_W,
    parameter int TOK_W    = TOKEN_W,
    parameter int BB_W     = BBOX_W,
    parameter int N_BBOX   = NUM_BBOX,
    localparam int VAL_W   = 2 * BB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [VAL_W-1:0]  val,
    output strobe_t           strb_q,
    output logic [TOK_W-1:0]  token_q,
    output logic [BB_W-1:0]   bb_upper_q,
    output logic [BB_W-1:0]   bb_lower_q
);
    strobe_t           dec;
    logic [N_BBOX-1:0] bb_hit;

    for (genvar i = 0; i < N_BBOX; i++) begin : g_bbox
        assign bb_hit[i] = (addr == (A_BBOX_BASE + ADDR_W'(i)));
    end

    always_comb begin
        dec           = '0;
        dec.finish    = (addr == A_DRAWDONE) && (val[7:0] == FINISH_CODE);
        dec.warn      = (addr == A_DRAWDONE) && (val[7:0] != FINISH_CODE);
        dec.token     = (addr == A_TOKEN) || (addr == A_TOKEN_IRQ);
        dec.token_irq = (addr == A_TOKEN_IRQ);
        dec.bbox      = bb_hit;
        dec.perf      = (addr == A_PERF_CLR);
        dec.scissor   = is_scissor(addr);
        dec.copy      = (addr == A_COPY);
        dec.texload   = (addr == A_TEXLOAD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strb_q     <= '0;
            token_q    <= '0;
            bb_upper_q <= '0;
            bb_lower_q <= '0;
        end else begin
            strb_q <= wr_en ? dec : '0;
            if (wr_en && dec.token) begin
                token_q <= val[TOK_W-1:0];
            end
            if (wr_en && (|bb_hit)) begin
                bb_upper_q <= val[VAL_W-1:BB_W];
                bb_lower_q <= val[BB_W-1:0];
            end
        end
    end
endmodule

// File: rtl/mcw_top.sv
module mcw_top
    import mcw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_valid,
    output logic                  cmd_ready,
    input  logic [MCW_CMD_W-1:0]  cmd_word,
    input  logic [MCW_ADDR_W-1:0] rd_addr,
    output logic [MCW_DATA_W-1:0] rd_data,
    output logic                  draw_finish,
    output logic                  draw_warn,
    output logic                  token_strobe,
    output logic                  token_irq,
    output logic [TOKEN_W-1:0]    token_value,
    output logic [NUM_BBOX-1:0]   bbox_load,
    output logic [BBOX_W-1:0]     bbox_upper,
    output logic [BBOX_W-1:0]     bbox_lower,
    output logic                  perf_clear,
    output logic                  scissor_changed,
    output logic                  copy_start,
    output logic                  texload_start
);
    localparam int VAL_W = 2 * BBOX_W;

    cmd_t                  cmd;
    logic                  accept;
    logic                  is_mask_wr;
    logic [MCW_DATA_W-1:0] file_old;
    logic [MCW_DATA_W-1:0] file_rd;
    logic [MCW_DATA_W-1:0] old_val;
    logic [MCW_DATA_W-1:0] merged;
    logic [MCW_DATA_W-1:0] mask_cur;
    strobe_t               strb_q;

    assign cmd        = cmd_t'(cmd_word);
    assign cmd_ready  = ~rst;
    assign accept     = cmd_valid & cmd_ready;
    assign is_mask_wr = (cmd.addr == A_MASK);
    assign old_val    = is_mask_wr ? mask_cur : file_old;

    mcw_mask_ctl #(
        .ADDR_W (MCW_ADDR_W),
        .DATA_W (MCW_DATA_W)
    ) u_mask (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (accept),
        .wr_addr (cmd.addr),
        .old_val (old_val),
        .payload (cmd.payload),
        .merged  (merged),
        .mask_q  (mask_cur)
    );

    mcw_regfile #(
        .ADDR_W (MCW_ADDR_W),
        .DATA_W (MCW_DATA_W)
    ) u_file (
        .clk      (clk),
        .rst      (rst),
        .we       (accept & ~is_mask_wr),
        .waddr    (cmd.addr),
        .wdata    (merged),
        .old_addr (cmd.addr),
        .old_data (file_old),
        .rd_addr  (rd_addr),
        .rd_data  (file_rd)
    );

    mcw_decode #(
        .ADDR_W (MCW_ADDR_W),
        .TOK_W  (TOKEN_W),
        .BB_W   (BBOX_W),
        .N_BBOX (NUM_BBOX)
    ) u_dec (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (accept),
        .addr       (cmd.addr),
        .val        (merged[VAL_W-1:0]),
        .strb_q     (strb_q),
        .token_q    (token_value),
        .bb_upper_q (bbox_upper),
        .bb_lower_q (bbox_lower)
    );

    assign rd_data         = (rd_addr == A_MASK) ? mask_cur : file_rd;
    assign draw_finish     = strb_q.finish;
    assign draw_warn       = strb_q.warn;
    assign token_strobe    = strb_q.token;
    assign token_irq       = strb_q.token_irq;
    assign bbox_load       = strb_q.bbox;
    assign perf_clear      = strb_q.perf;
    assign scissor_changed = strb_q.scissor;
    assign copy_start      = strb_q.copy;
    assign texload_start   = strb_q.texload;
endmodule

// File: rtl/mcw_checker.sv
module mcw_checker
    import mcw_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  cmd_valid,
    input logic                  cmd_ready,
    input logic [MCW_CMD_W-1:0]  cmd_word,
    input logic [MCW_DATA_W-1:0] mask_cur,
    input logic                  draw_finish,
    input logic                  draw_warn,
    input logic                  token_strobe,
    input logic                  token_irq,
    input logic [NUM_BBOX-1:0]   bbox_load,
    input logic                  perf_clear,
    input logic                  scissor_changed,
    input logic                  copy_start,
    input logic                  texload_start
);
    logic                  acc;
    logic [MCW_ADDR_W-1:0] a;
    logic                  any_strobe;

    assign acc = cmd_valid && cmd_ready;
    assign a   = cmd_word[MCW_CMD_W-1:MCW_DATA_W];
    assign any_strobe = draw_finish | draw_warn | token_strobe | token_irq | (|bbox_load)
                      | perf_clear | scissor_changed | copy_start | texload_start;

    AST_MASK_REVERT: assert property (@(posedge clk) disable iff (rst)
        (acc && a != A_MASK) |=> (mask_cur == '1)); // R4

    AST_MASK_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !acc |=> $stable(mask_cur)); // R4

    AST_FINISH_WARN_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(draw_finish && draw_warn)); // R5

    AST_FINISH_ADDR: assert property (@(posedge clk) disable iff (rst)
        draw_finish |-> $past(acc && a == A_DRAWDONE)); // R5

    AST_IRQ_WITH_TOKEN: assert property (@(posedge clk) disable iff (rst)
        token_irq |-> token_strobe); // R6

    AST_STROBE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        any_strobe |-> $past(acc)); // R10

    AST_ONE_CLASS: assert property (@(posedge clk) disable iff (rst)
        $onehot0({draw_finish, draw_warn, token_strobe, bbox_load,
                  perf_clear, scissor_changed, copy_start, texload_start})); // R10
endmodule

bind mcw_top mcw_checker u_chk (
    .clk             (clk),
    .rst             (rst),
    .cmd_valid       (cmd_valid),
    .cmd_ready       (cmd_ready),
    .cmd_word        (cmd_word),
    .mask_cur        (mask_cur),
    .draw_finish     (draw_finish),
    .draw_warn       (draw_warn),
    .token_strobe    (token_strobe),
    .token_irq       (token_irq),
    .bbox_load       (bbox_load),
    .perf_clear      (perf_clear),
    .scissor_changed (scissor_changed),
    .copy_start      (copy_start),
    .texload_start   (texload_start)
);

// File: tb/tb_mcw_top.sv
`timescale 1ns/1ps
module tb_mcw_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_word = '0;
    logic [7:0]  rd_addr = '0;
    logic [23:0] rd_data;
    logic        draw_finish, draw_warn, token_strobe, token_irq;
    logic [15:0] token_value;
    logic [1:0]  bbox_load;
    logic [9:0]  bbox_upper, bbox_lower;
    logic        perf_clear, scissor_changed, copy_start, texload_start;

    int n_chk  = 0;
    int n_fail = 0;

    logic [23:0] mdl_mem [256];
    logic [23:0] mdl_mask;
    logic [7:0]  pend_addr;
    logic [23:0] pend_val;
    bit          pend_on = 0;

    always #4 clk = ~clk;

    mcw_top dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_word(cmd_word), .rd_addr(rd_addr), .rd_data(rd_data),
        .draw_finish(draw_finish), .draw_warn(draw_warn),
        .token_strobe(token_strobe), .token_irq(token_irq), .token_value(token_value),
        .bbox_load(bbox_load), .bbox_upper(bbox_upper), .bbox_lower(bbox_lower),
        .perf_clear(perf_clear), .scissor_changed(scissor_changed),
        .copy_start(copy_start), .texload_start(texload_start)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] strb_vec();
        return {draw_finish, draw_warn, token_strobe, token_irq, bbox_load,
                perf_clear, scissor_changed, copy_start, texload_start};
    endfunction

    // Expected strobes per address, from R5..R10
    function automatic logic [9:0] exp_strb(input logic [7:0] a, input logic [23:0] v);
        logic [9:0] e = '0;
        e[9] = (a == 8'h45) && (v[7:0] == 8'h02);
        e[8] = (a == 8'h45) && (v[7:0] != 8'h02);
        e[7] = (a == 8'h47) || (a == 8'h48);
        e[6] = (a == 8'h48);
        e[5] = (a == 8'h56);
        e[4] = (a == 8'h55);
        e[3] = (a == 8'h57);
        e[2] = (a == 8'h20) || (a == 8'h21) || (a == 8'h59);
        e[1] = (a == 8'h52);
        e[0] = (a == 8'h65);
        return e;
    endfunction

    function automatic string req_of(input logic [7:0] a);
        case (a)
            8'h45:               return "R5";
            8'h47, 8'h48:        return "R6";
            8'h55, 8'h56:        return "R7";
            8'h20, 8'h21, 8'h59: return "R8";
            8'h52, 8'h57, 8'h65: return "R9";
            default:             return "R10";
        endcase
    endfunction

    // Drive a command at the current (negedge) time and update the model
    task automatic drive(input logic [7:0] a, input logic [23:0] p);
        logic [23:0] old;
        logic [23:0] mrg;
        old = (a == 8'hFE) ? mdl_mask : mdl_mem[a];
        mrg = (old & ~mdl_mask) | (p & mdl_mask);   // R2
        if (a == 8'hFE) mdl_mask = mrg;
        else begin
            mdl_mem[a] = mrg;
            mdl_mask   = 24'hFFFFFF;                 // R4
        end
        cmd_valid = 1'b1;
        cmd_word  = {a, p};
        pend_addr = a;
        pend_val  = mrg;
        pend_on   = 1;
    endtask

    // Called one negedge after the accepting edge
    task automatic check_pending();
        if (pend_on) begin
            rd_addr = pend_addr;
            #1;
            chk("R1_R2 rd_data", {8'h0, rd_data}, {8'h0, pend_val});
            chk(req_of(pend_addr), {22'h0, strb_vec()}, {22'h0, exp_strb(pend_addr, pend_val)});
            if (pend_addr == 8'h47 || pend_addr == 8'h48)
                chk("R6 token_value", {16'h0, token_value}, {16'h0, pend_val[15:0]});
            if (pend_addr == 8'h55 || pend_addr == 8'h56) begin
                chk("R7 bbox_upper", {22'h0, bbox_upper}, {22'h0, pend_val[19:10]});
                chk("R7 bbox_lower", {22'h0, bbox_lower}, {22'h0, pend_val[9:0]});
            end
            pend_on = 0;
        end
    endtask

    task automatic send(input logic [7:0] a, input logic [23:0] p);
        @(negedge clk);
        drive(a, p);
        @(negedge clk);
        cmd_valid = 1'b0;
        check_pending();
    endtask

    task automatic idle_check();
        @(negedge clk);
        #1;
        chk("R10 strobes drop", {22'h0, strb_vec()}, 32'h0);
    endtask

    task automatic check_mask(input string req);
        rd_addr = 8'hFE;
        #1;
        chk(req, {8'h0, rd_data}, {8'h0, mdl_mask});
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int i = 0; i < 256; i++) mdl_mem[i] = '0;
        mdl_mask = 24'hFFFFFF;
        repeat (3) @(negedge clk);
        chk("R1 ready low in reset", {31'h0, cmd_ready}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready after reset", {31'h0, cmd_ready}, 32'h1);
        chk("R3 no strobe after reset", {22'h0, strb_vec()}, 32'h0);
        for (int i = 0; i < 256; i++) begin
            rd_addr = 8'(i);
            #1;
            chk("R3 reset contents", {8'h0, rd_data},
                (i == 254) ? 32'h00FFFFFF : 32'h0);
        end

        // Full-mask sweep of every address except the mask
        for (int i = 0; i < 256; i++) begin
            if (i != 254) begin
                send(8'(i), {8'(i), ~8'(i), 8'(i) ^ 8'h5A});
                idle_check();
            end
        end
        check_mask("R4 mask untouched by sweep");

        // Draw-done code sweep
        for (int b = 0; b < 256; b++) begin
            send(8'h45, {8'h00, 8'h13, 8'(b)});
        end

        // Partial masks: one write uses them, the next does not
        for (int k = 0; k < 6; k++) begin
            logic [23:0] m;
            logic [7:0]  tgt;
            m   = 24'h00F0F0 ^ (24'h111111 * 24'(k));
            tgt = 8'h30 + 8'(k);
            send(8'hFE, m);
            check_mask("R4 mask loaded");
            send(tgt, 24'hA5C3E1 ^ 24'(k));
            check_mask("R4 mask reverted");
            send(tgt, 24'h0F1E2D);
        end

        // Two mask writes in a row: second merges with the first
        send(8'hFE, 24'h00FF00);
        send(8'hFE, 24'h123456);
        check_mask("R4 chained mask");
        send(8'h3A, 24'hFFFFFF);

        // Mask then strobing register: side data uses the merged value
        send(8'hFE, 24'h0000FF);
        send(8'h47, 24'hABCDEF);
        send(8'hFE, 24'h0FFC00);
        send(8'h55, 24'hFFFFFF);
        send(8'hFE, 24'hFFFF00);
        send(8'h45, 24'h000002);
        send(8'hFE, 24'h0000FF);
        send(8'h45, 24'h000302);
        send(8'h48, 24'h00BEEF);

        // Back-to-back: mask, two writes, strobes, each cycle (R11)
        @(negedge clk);
        drive(8'hFE, 24'h00000F);
        @(negedge clk); check_pending(); drive(8'h40, 24'hFFFFFF);
        @(negedge clk); check_pending(); drive(8'h41, 24'hFFFFFF);
        @(negedge clk); check_pending(); drive(8'h56, 24'h0ABCDE);
        @(negedge clk); check_pending(); drive(8'h20, 24'h000001);
        @(negedge clk); check_pending(); drive(8'h59, 24'h000002);
        @(negedge clk); check_pending(); drive(8'h52, 24'h000003);
        @(negedge clk); check_pending();
        cmd_valid = 1'b0;
        rd_addr = 8'h40; #1;
        chk("R11 first after mask", {8'h0, rd_data}, {8'h0, mdl_mem[8'h40]});
        rd_addr = 8'h41; #1;
        chk("R11 second full", {8'h0, rd_data}, 32'h00FFFFFF);
        idle_check();

        summary();
    end
endmodule